// File: doc/BRIEF.md
# Tiled Surface Stride Validator

This block decides whether a requested surface layout can be used. It takes a tiling mode, a hardware generation number, a capability flag for narrow Y tiles, a row stride in bytes and an object size in bytes. It returns a pass flag and a reason code that names the first rule the request breaks. The rules change with the generation: the tile width, the largest stride allowed, whether the object size is limited, and whether the stride must be a power of two or only a whole number of tiles.

All checks are combinational. The verdict is captured in an output register, so the result for the inputs present at one rising clock edge appears on the outputs after that edge. Software or an allocation engine can present one request per cycle and read the verdict one cycle later.

Top module: `tiled_stride_checker`

## Requirements
- R1: Tiling mode code 0 (linear) is always accepted with reason 0, whatever the stride, size and generation. Mode code 2 is Y tiling. Codes 1 and 3 are X tiling.
- R2: The tile width is 128 bytes when the generation is 2 or lower, or when the mode is Y and the narrow-Y capability flag is 1. In every other case it is 512 bytes.
- R3: A tiled request whose stride is below the tile width is rejected with reason 1.
- R4: For generation 7 and above, the stride shifted right by 7 must not exceed PITCH_MAX_NEW (default 2047). For generations 4 to 6 it must not exceed PITCH_MAX_MID (default 511). A request that breaks this gets reason 2.
- R5: For generation 3 and below, a stride above 8192 bytes gets reason 2.
- R6: On generation 3, an object size above SIZE_UNITS<<20 gets reason 3. On generation 2 and below the limit is SIZE_UNITS<<19 (SIZE_UNITS defaults to 64). From generation 4 on, the size has no effect on the verdict.
- R7: For generation 4 and above, a stride that is not an exact multiple of the tile width gets reason 4.
- R8: For generation 3 and below, a stride that is not a power of two gets reason 4.
- R9: The checks are ranked 1, 2, 3, 4 and the lowest-numbered failing check is reported. ok is 1 exactly when the reason is 0.
- R10: The verdict for the inputs sampled at a rising edge appears after that edge and holds until the next one. Synchronous reset sets ok to 1 and reason to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_mode | input | 2 | 0 linear, 2 Y tiling, 1 or 3 X tiling |
| gen | input | 4 | Hardware generation number |
| y128_cap | input | 1 | 1 selects 128-byte Y tiles |
| stride | input | STRIDE_W (20) | Row stride in bytes |
| obj_size | input | SIZE_W (32) | Object size in bytes |
| ok | output | 1 | Registered pass flag |
| reason | output | 3 | Registered reason code: 0 ok, 1 below tile width, 2 stride too large, 3 size too large, 4 misaligned or not a power of two |

## Verification
One request can break several rules in the same cycle. Examples are a stride that is both too large and not a power of two on an early generation, or an oversized stride together with an oversized object on generation 3. The sweep crosses stride values just below, at and above each limit with object sizes on either side of both size limits, over every mode, both capability settings and a spread of generations. Each registered verdict is compared one cycle later with a reason computed arithmetically in the bench, which applies the ranking in R9. When several rules fail, only the lowest-ranked code is accepted.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [1:0] {
        TM_LINEAR = 2'd0,
        TM_X      = 2'd1,
        TM_Y      = 2'd2,
        TM_X_ALT  = 2'd3
    } tile_mode_e;

    typedef enum logic [2:0] {
        RS_OK        = 3'd0,
        RS_NARROW    = 3'd1,
        RS_WIDE      = 3'd2,
        RS_BIG_OBJ   = 3'd3,
        RS_MISALIGN  = 3'd4
    } reason_e;

    typedef struct packed {
        logic early;   // generation 2 or lower
        logic third;   // generation 3
        logic modern;  // generation 4 or higher
        logic newest;  // generation 7 or higher
    } gen_class_t;

    typedef struct packed {
        logic    pass;
        reason_e code;
    } verdict_t;

    localparam int NARROW_TILE_B = 128;
    localparam int WIDE_TILE_B   = 512;
    localparam int EARLY_STRIDE_MAX = 8192;
    localparam int PITCH_SHIFT   = 7;

    function automatic gen_class_t classify_gen(input logic [3:0] g);
        gen_class_t c;
        c.early  = (g <= 4'd2);
        c.third  = (g == 4'd3);
        c.modern = (g >= 4'd4);
        c.newest = (g >= 4'd7);
        return c;
    endfunction

endpackage

// File: rtl/tsc_width_sel.sv
module tsc_width_sel
    import tsc_pkg::*;
#(
    parameter int STRIDE_W = 20
) (
    input  tile_mode_e            mode,
    input  gen_class_t            cls,
    input  logic                  y128_cap,
    output logic [STRIDE_W-1:0]   tile_w
);
    logic narrow;

    always_comb begin
        narrow = cls.early || ((mode == TM_Y) && y128_cap);
        tile_w = narrow ? STRIDE_W'(NARROW_TILE_B) : STRIDE_W'(WIDE_TILE_B);
    end

    always_comb begin
        a_r2_width_legal: assert ((tile_w == STRIDE_W'(NARROW_TILE_B)) ||
                                  (tile_w == STRIDE_W'(WIDE_TILE_B)));
    end
endmodule

// File: rtl/tsc_limit_chk.sv
module tsc_limit_chk
    import tsc_pkg::*;
#(
    parameter int STRIDE_W      = 20,
    parameter int SIZE_W        = 32,
    parameter int PITCH_MAX_MID = 511,
    parameter int PITCH_MAX_NEW = 2047,
    parameter int SIZE_UNITS    = 64
) (
    input  gen_class_t           cls,
    input  logic [STRIDE_W-1:0]  stride,
    input  logic [SIZE_W-1:0]    obj_size,
    output logic                 stride_big,
    output logic                 size_big
);
    localparam longint unsigned G3_SIZE_MAX = longint'(SIZE_UNITS) << 20;
    localparam longint unsigned G2_SIZE_MAX = longint'(SIZE_UNITS) << 19;

    logic [STRIDE_W-1:0] pitch_units;
    logic [63:0]         size_ext;
    logic                pitch_over;
    logic                early_over;

    always_comb begin
        pitch_units = stride >> PITCH_SHIFT;
        size_ext    = 64'(obj_size);
        if (cls.newest)
            pitch_over = pitch_units > STRIDE_W'(PITCH_MAX_NEW);
        else
            pitch_over = pitch_units > STRIDE_W'(PITCH_MAX_MID);
        early_over = stride > STRIDE_W'(EARLY_STRIDE_MAX);
        stride_big = cls.modern ? pitch_over : early_over;
        if (cls.third)
            size_big = size_ext > G3_SIZE_MAX;
        else if (cls.early)
            size_big = size_ext > G2_SIZE_MAX;
        else
            size_big = 1'b0;
    end

    always_comb begin
        a_r6_size_ignored_modern: assert (!(cls.modern && size_big));
    end
endmodule

// File: rtl/tsc_align_chk.sv
module tsc_align_chk
    import tsc_pkg::*;
#(
    parameter int STRIDE_W = 20
) (
    input  gen_class_t           cls,
    input  logic [STRIDE_W-1:0]  stride,
    input  logic [STRIDE_W-1:0]  tile_w,
    output logic                 below_tile,
    output logic                 misaligned
);
    logic not_multiple;
    logic not_pow2;

    always_comb begin
        below_tile   = stride < tile_w;
        not_multiple = (stride & (tile_w - STRIDE_W'(1))) != '0;
        not_pow2     = (stride & (stride - STRIDE_W'(1))) != '0;
        misaligned   = cls.modern ? not_multiple : not_pow2;
    end
endmodule

// File: rtl/tiled_stride_checker.sv
module tiled_stride_checker
    import tsc_pkg::*;
#(
    parameter int STRIDE_W      = 20,
    parameter int SIZE_W        = 32,
    parameter int PITCH_MAX_MID = 511,
    parameter int PITCH_MAX_NEW = 2047,
    parameter int SIZE_UNITS    = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           tile_mode,
    input  logic [3:0]           gen,
    input  logic                 y128_cap,
    input  logic [STRIDE_W-1:0]  stride,
    input  logic [SIZE_W-1:0]    obj_size,
    output logic                 ok,
    output logic [2:0]           reason
);
    tile_mode_e          mode;
    gen_class_t          cls;
    logic [STRIDE_W-1:0] tile_w;
    logic                below_tile, misaligned, stride_big, size_big;
    verdict_t            next_v, cur_v;

    assign mode = tile_mode_e'(tile_mode);
    assign cls  = classify_gen(gen);

    tsc_width_sel #(.STRIDE_W(STRIDE_W)) u_width (
        .mode(mode), .cls(cls), .y128_cap(y128_cap), .tile_w(tile_w)
    );

    tsc_limit_chk #(
        .STRIDE_W(STRIDE_W), .SIZE_W(SIZE_W),
        .PITCH_MAX_MID(PITCH_MAX_MID), .PITCH_MAX_NEW(PITCH_MAX_NEW),
        .SIZE_UNITS(SIZE_UNITS)
    ) u_limit (
        .cls(cls), .stride(stride), .obj_size(obj_size),
        .stride_big(stride_big), .size_big(size_big)
    );

    tsc_align_chk #(.STRIDE_W(STRIDE_W)) u_align (
        .cls(cls), .stride(stride), .tile_w(tile_w),
        .below_tile(below_tile), .misaligned(misaligned)
    );

    always_comb begin
        next_v.pass = 1'b0;
        if (mode == TM_LINEAR)  next_v.code = RS_OK;
        else if (below_tile)    next_v.code = RS_NARROW;
        else if (stride_big)    next_v.code = RS_WIDE;
        else if (size_big)      next_v.code = RS_BIG_OBJ;
        else if (misaligned)    next_v.code = RS_MISALIGN;
        else                    next_v.code = RS_OK;
        next_v.pass = (next_v.code == RS_OK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_v.pass <= 1'b1;
            cur_v.code <= RS_OK;
        end else begin
            cur_v <= next_v;
        end
    end

    assign ok     = cur_v.pass;
    assign reason = cur_v.code;

    a_r1_linear_ok: assert property (@(posedge clk) disable iff (rst)
        (tile_mode == 2'd0) |=> (ok && reason == 3'd0));

    a_r3_narrow_stride: assert property (@(posedge clk) disable iff (rst)
        (reason == 3'd1) |-> ($past(stride) < STRIDE_W'(WIDE_TILE_B)));

    a_r4_modern_pitch: assert property (@(posedge clk) disable iff (rst)
        (reason == 3'd2 && $past(gen) >= 4'd4) |->
        (($past(stride) >> PITCH_SHIFT) > STRIDE_W'(PITCH_MAX_MID)));

    a_r6_size_early_only: assert property (@(posedge clk) disable iff (rst)
        (reason == 3'd3) |-> ($past(gen) <= 4'd3));

    a_r8_pow2_early: assert property (@(posedge clk) disable iff (rst)
        (reason == 3'd4 && $past(gen) <= 4'd3) |-> ($countones($past(stride)) != 1));

    a_r9_flag_matches: assert property (@(posedge clk) disable iff (rst)
        ok == (reason == 3'd0));
endmodule

// File: tb/sim_tiled_stride_checker.sv
module sim_tiled_stride_checker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  tile_mode = 2'd0;
    logic [3:0]  gen = 4'd2;
    logic        y128_cap = 1'b0;
    logic [19:0] stride = '0;
    logic [31:0] obj_size = '0;
    logic        ok;
    logic [2:0]  reason;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tiled_stride_checker u0 (
        .clk(clk), .rst(rst), .tile_mode(tile_mode), .gen(gen),
        .y128_cap(y128_cap), .stride(stride), .obj_size(obj_size),
        .ok(ok), .reason(reason)
    );

    function automatic int exp_reason(int m, int g, int cap, longint s, longint sz);
        longint tw;
        tw = (g <= 2 || (m == 2 && cap == 1)) ? 128 : 512;
        if (m == 0) return 0;
        if (s < tw) return 1;
        if (g >= 7) begin
            if (s / 128 > 2047) return 2;
        end else if (g >= 4) begin
            if (s / 128 > 511) return 2;
        end else if (s > 8192) return 2;
        if (g == 3 && sz > (longint'(64) << 20)) return 3;
        if (g <= 2 && sz > (longint'(64) << 19)) return 3;
        if (g >= 4) begin
            if (s % tw != 0) return 4;
        end else if ((s & (s - 1)) != 0) return 4;
        return 0;
    endfunction

    function automatic string tag_of(int m, int g, int cap, int r);
        if (m == 0) return "R1";
        case (r)
            1: return (g <= 2 || (m == 2 && cap == 1)) ? "R2/R3" : "R3";
            2: return (g >= 4) ? "R4" : "R5";
            3: return "R6";
            4: return (g >= 4) ? "R7" : "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic exp_ok, int exp_r);
        compared++;
        if (ok !== exp_ok || reason !== 3'(exp_r)) begin
            mismatched++;
            $display("FAIL %s: ok=%0b reason=%0d expected ok=%0b reason=%0d (mode=%0d gen=%0d cap=%0b stride=%0d size=%0d)",
                     tag, ok, reason, exp_ok, exp_r, tile_mode, gen, y128_cap, stride, obj_size);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int gens[]    = '{0, 2, 3, 4, 5, 6, 7, 8, 15};
        int strides[] = '{0, 64, 127, 128, 192, 256, 384, 512, 640, 1024, 1536,
                          2048, 4096, 8192, 8704, 16384, 65408, 65536, 65920,
                          262016, 262144, 262528};
        longint sizes[] = '{4096, 33554432, 33554433, 67108864, 67108865};
        int r;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check("R10", 1'b1, 0);
        rst = 1'b0;

        // R10: output changes only after the edge
        tile_mode = 2'd1; gen = 4'd4; stride = 20'd100; obj_size = 32'd4096;
        #1 check("R10", 1'b1, 0);
        @(posedge clk); @(negedge clk);
        check("R10/R3", 1'b0, 1);

        for (int gi = 0; gi < gens.size(); gi++)
            for (int m = 0; m < 4; m++)
                for (int cap = 0; cap < 2; cap++)
                    for (int si = 0; si < strides.size(); si++)
                        for (int zi = 0; zi < sizes.size(); zi++) begin
                            tile_mode = 2'(m);
                            gen       = 4'(gens[gi]);
                            y128_cap  = 1'(cap);
                            stride    = 20'(strides[si]);
                            obj_size  = 32'(sizes[zi]);
                            @(posedge clk); @(negedge clk);
                            r = exp_reason(m, gens[gi], cap, strides[si], sizes[zi]);
                            check(tag_of(m, gens[gi], cap, r), (r == 0), r);
                        end

        // R10: reset mid-run restores pass state
        tile_mode = 2'd2; gen = 4'd3; stride = 20'd9000;
        @(posedge clk); @(negedge clk);
        check("R5", 1'b0, 2);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10", 1'b1, 0);
        rst = 1'b0;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule